// File: doc/BRIEF.md
# Shifter operand unit with carry-out

This block produces the second operand of a 32-bit integer datapath. A source word is shifted or rotated by an amount that comes either from a 5-bit field of the instruction or from the low 8 bits of a register. The block returns the shifted word and a shifter carry that the flag logic downstream may take as its new carry. The logic is purely combinational, and its outputs follow its inputs in the same cycle.

Four shift kinds are supported. Amounts of zero, exactly the word width, and above the word width each follow fixed rules for both the value and the carry. An immediate amount of zero is a special encoding: it means a full-width shift for the right shifts, and a one-bit rotate through the carry for the rotate kind. The block also raises a flag when the amount was taken from a register, so that the sequencer can add the extra cycle that path costs.

Top module: `shifter_operand_unit`

## Requirements
- R1: With `shift_kind` = 0 (logical left) and an effective amount n from 1 to 31, `result` is the source shifted left by n, and `carry_out` is source bit 32-n.
- R2: With `shift_kind` = 1 (logical right) or 2 (arithmetic right) and an amount n from 1 to 31, `result` is the source shifted right by n, with zeros filled for kind 1 and copies of bit 31 filled for kind 2. `carry_out` is source bit n-1.
- R3: With `shift_kind` = 3 (rotate right) and an amount whose value modulo 32, m, is not zero, `result` is the source rotated right by m, and `carry_out` is source bit m-1.
- R4: When `amt_from_reg` = 1 and `reg_amt` = 0, `result` equals the source and `carry_out` equals `carry_in`, for every shift kind.
- R5: For logical left, an immediate amount of 0 passes the source through with `carry_out` = `carry_in`. An amount of 32 gives 0 with `carry_out` = source bit 0. Amounts above 32 give 0 with `carry_out` = 0.
- R6: For logical right, an immediate amount of 0 acts as 32. An amount of 32 gives 0 with `carry_out` = source bit 31. Amounts above 32 give 0 with `carry_out` = 0.
- R7: For arithmetic right, an immediate amount of 0 acts as 32. Any amount of 32 or more gives every bit equal to source bit 31, and `carry_out` equals source bit 31.
- R8: For rotate right, an immediate amount of 0 gives `{carry_in, source[31:1]}`, with `carry_out` = source bit 0.
- R9: For rotate right with a register amount that is a nonzero multiple of 32, `result` equals the source and `carry_out` is source bit 31.
- R10: `extra_cycle` equals `amt_from_reg`.
- R11: The amount field that `amt_from_reg` does not select has no effect on `result` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | 32 | Word to be shifted |
| shift_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_from_reg | input | 1 | 1 selects `reg_amt`, 0 selects `imm_amt` |
| imm_amt | input | 5 | Amount taken from the instruction |
| reg_amt | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Shifter carry |
| extra_cycle | output | 1 | The amount came from a register |

## Verification
The special zero encoding and the full-width boundary can both act on one input. An immediate zero on a right shift has to produce the same value and carry as a register amount of exactly 32, and a rotate must tell an immediate zero (one step through the carry) apart from a register multiple of 32 (unchanged word, carry from bit 31). The stimulus sweeps every register amount from 0 to 255 and every immediate amount for all four kinds, over several source words and both carry values. Each result is compared with a model built on double-width arithmetic, so the same boundary is reached on both paths and the two outcomes are judged against each other.

// File: rtl/shifter_operand_pkg.sv
package shifter_operand_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        OPM_PASS  = 2'd0,
        OPM_RRX   = 2'd1,
        OPM_SHIFT = 2'd2
    } op_mode_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/shop_amount_decode.sv
module shop_amount_decode
    import shifter_operand_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 5,
    parameter int REG_AMT_W = 8,
    parameter int AMT_W     = 9
) (
    input  shift_kind_e          kind,
    input  logic                 from_reg,
    input  logic [IMM_W-1:0]     imm_amt,
    input  logic [REG_AMT_W-1:0] reg_amt,
    output op_mode_e             mode,
    output logic [AMT_W-1:0]     amt
);

    always_comb begin
        mode = OPM_SHIFT;
        amt  = '0;
        if (from_reg) begin
            // register amount: zero always means pass through
            amt = AMT_W'(reg_amt);
            if (reg_amt == '0) mode = OPM_PASS;
        end else if (imm_amt == '0) begin
            // immediate zero is a special encoding per kind
            case (kind)
                SK_LSL:  mode = OPM_PASS;
                SK_ROR:  mode = OPM_RRX;
                default: amt  = AMT_W'(DATA_W);
            endcase
        end else begin
            amt = AMT_W'(imm_amt);
        end
    end

endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
    import shifter_operand_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 9
) (
    input  shift_kind_e       kind,
    input  op_mode_e          mode,
    input  logic [AMT_W-1:0]  amt,
    input  logic [DATA_W-1:0] src,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int LOG_W = $clog2(DATA_W);

    logic [LOG_W-1:0] rot_amt;
    logic             amt_below;
    logic             amt_equal;
    int               n;

    assign rot_amt   = amt[LOG_W-1:0];
    assign amt_below = (amt < AMT_W'(DATA_W));
    assign amt_equal = (amt == AMT_W'(DATA_W));

    always_comb begin
        res  = src;
        cout = cin;
        n    = int'(amt);
        case (mode)
            OPM_RRX: begin
                res  = {cin, src[DATA_W-1:1]};
                cout = src[0];
            end
            OPM_SHIFT: begin
                case (kind)
                    SK_LSL: begin
                        if (amt_below) begin
                            res  = src << amt;
                            cout = src[LOG_W'(DATA_W - n)];
                        end else begin
                            res  = '0;
                            cout = amt_equal ? src[0] : 1'b0;
                        end
                    end
                    SK_LSR: begin
                        if (amt_below) begin
                            res  = src >> amt;
                            cout = src[LOG_W'(n - 1)];
                        end else begin
                            res  = '0;
                            cout = amt_equal ? src[DATA_W-1] : 1'b0;
                        end
                    end
                    SK_ASR: begin
                        if (amt_below) begin
                            res  = $signed(src) >>> amt;
                            cout = src[LOG_W'(n - 1)];
                        end else begin
                            res  = {DATA_W{src[DATA_W-1]}};
                            cout = src[DATA_W-1];
                        end
                    end
                    default: begin
                        if (rot_amt == '0) begin
                            res  = src;
                            cout = src[DATA_W-1];
                        end else begin
                            res  = (src >> rot_amt) | (src << (DATA_W - int'(rot_amt)));
                            cout = src[rot_amt - LOG_W'(1)];
                        end
                    end
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
    import shifter_operand_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 5,
    parameter int REG_AMT_W = 8
) (
    input  logic [DATA_W-1:0]    src_val,
    input  logic [1:0]           shift_kind,
    input  logic                 amt_from_reg,
    input  logic [IMM_W-1:0]     imm_amt,
    input  logic [REG_AMT_W-1:0] reg_amt,
    input  logic                 carry_in,
    output logic [DATA_W-1:0]    result,
    output logic                 carry_out,
    output logic                 extra_cycle
);

    localparam int LOG_W = $clog2(DATA_W);
    localparam int AMT_W = max_int(LOG_W + 1, REG_AMT_W);

    shift_kind_e      kind;
    op_mode_e         mode;
    logic [AMT_W-1:0] eff_amt;

    assign kind        = shift_kind_e'(shift_kind);
    assign extra_cycle = amt_from_reg;

    shop_amount_decode #(
        .DATA_W    (DATA_W),
        .IMM_W     (IMM_W),
        .REG_AMT_W (REG_AMT_W),
        .AMT_W     (AMT_W)
    ) u_decode (
        .kind     (kind),
        .from_reg (amt_from_reg),
        .imm_amt  (imm_amt),
        .reg_amt  (reg_amt),
        .mode     (mode),
        .amt      (eff_amt)
    );

    shop_shift_core #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_core (
        .kind (kind),
        .mode (mode),
        .amt  (eff_amt),
        .src  (src_val),
        .cin  (carry_in),
        .res  (result),
        .cout (carry_out)
    );

endmodule

// File: rtl/shifter_operand_checker.sv
module shifter_operand_checker #(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 5,
    parameter int REG_AMT_W = 8
) (
    input logic [DATA_W-1:0]    src_val,
    input logic [1:0]           shift_kind,
    input logic                 amt_from_reg,
    input logic [IMM_W-1:0]     imm_amt,
    input logic [REG_AMT_W-1:0] reg_amt,
    input logic                 carry_in,
    input logic [DATA_W-1:0]    result,
    input logic                 carry_out,
    input logic                 extra_cycle
);

    localparam int LOG_W = $clog2(DATA_W);

    always_comb begin
        if (!$isunknown({src_val, shift_kind, amt_from_reg, imm_amt, reg_amt, carry_in})) begin
            if (amt_from_reg && reg_amt == '0) begin
                a_r4_reg_zero_pass: assert (result == src_val && carry_out == carry_in);
            end
            if (!amt_from_reg && imm_amt == '0 && shift_kind == 2'd3) begin
                a_r8_rrx: assert (result == {carry_in, src_val[DATA_W-1:1]} && carry_out == src_val[0]);
            end
            if (shift_kind == 2'd2 && (amt_from_reg ? (int'(reg_amt) >= DATA_W) : (imm_amt == '0))) begin
                a_r7_sign_fill: assert (result == {DATA_W{src_val[DATA_W-1]}} && carry_out == src_val[DATA_W-1]);
            end
            // R5 and R6: logical shifts beyond the width flush value and carry
            if (shift_kind[1] == 1'b0 && amt_from_reg && int'(reg_amt) > DATA_W) begin
                a_r6_flush: assert (result == '0 && carry_out == 1'b0);
            end
            if (shift_kind == 2'd3 && amt_from_reg && reg_amt != '0 && reg_amt[LOG_W-1:0] == '0) begin
                a_r9_rot_full: assert (result == src_val && carry_out == src_val[DATA_W-1]);
            end
        end
    end

endmodule

bind shifter_operand_unit shifter_operand_checker #(
    .DATA_W    (DATA_W),
    .IMM_W     (IMM_W),
    .REG_AMT_W (REG_AMT_W)
) u_checker (.*);

// File: tb/shifter_operand_unit_bench.sv
`timescale 1ns/1ps
module shifter_operand_unit_bench;

    typedef struct {
        logic [31:0] exp_res;
        logic        exp_c;
        logic        exp_x;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_val = '0;
    logic [1:0]  shift_kind = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  imm_amt = '0;
    logic [7:0]  reg_amt = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;
    logic        extra_cycle;

    int total = 0;
    int fails = 0;
    exp_item_t q[$];

    always #2.5 clk = ~clk;

    shifter_operand_unit u_shifter_operand_unit (
        .src_val      (src_val),
        .shift_kind   (shift_kind),
        .amt_from_reg (amt_from_reg),
        .imm_amt      (imm_amt),
        .reg_amt      (reg_amt),
        .carry_in     (carry_in),
        .result       (result),
        .carry_out    (carry_out),
        .extra_cycle  (extra_cycle)
    );

    // double-width model of the requirements
    function automatic void ref_model(
        input  logic [1:0]  k,
        input  logic        fr,
        input  logic [4:0]  ia,
        input  logic [7:0]  ra,
        input  logic [31:0] v,
        input  logic        ci,
        output logic [31:0] r,
        output logic        c,
        output string       tag
    );
        int n;
        int m;
        logic [63:0]        p;
        logic signed [63:0] s;
        n = fr ? int'(ra) : int'(ia);
        r = v;
        c = ci;
        if (fr && n == 0) begin
            tag = "R4";
            return;
        end
        case (k)
            2'd0: begin
                if (n == 0) begin
                    tag = "R5";
                end else if (n <= 32) begin
                    p = {32'b0, v} << n;
                    r = p[31:0];
                    c = p[32];
                    tag = (n == 32) ? "R5" : "R1";
                end else begin
                    r = '0; c = 1'b0; tag = "R5";
                end
            end
            2'd1: begin
                if (n == 0) n = 32;
                if (n <= 32) begin
                    p = {v, 32'b0} >> n;
                    r = p[63:32];
                    c = p[31];
                end else begin
                    r = '0; c = 1'b0;
                end
                tag = (n >= 32) ? "R6" : "R2";
            end
            2'd2: begin
                if (n == 0 || n > 32) n = 32;
                s = $signed({v, 32'b0}) >>> n;
                r = s[63:32];
                c = s[31];
                tag = (n == 32) ? "R7" : "R2";
            end
            default: begin
                if (!fr && n == 0) begin
                    r = {ci, v[31:1]};
                    c = v[0];
                    tag = "R8";
                end else begin
                    m = n % 32;
                    if (m == 0) begin
                        c = v[31];
                        tag = "R9";
                    end else begin
                        p = {v, v} >> m;
                        r = p[31:0];
                        c = r[31];
                        tag = "R3";
                    end
                end
            end
        endcase
    endfunction

    task automatic apply(input logic [1:0] k, input logic fr, input logic [4:0] ia,
                         input logic [7:0] ra, input logic [31:0] v, input logic ci,
                         input string force_tag);
        exp_item_t it;
        @(posedge clk);
        #1;
        shift_kind   = k;
        amt_from_reg = fr;
        imm_amt      = ia;
        reg_amt      = ra;
        src_val      = v;
        carry_in     = ci;
        ref_model(k, fr, ia, ra, v, ci, it.exp_res, it.exp_c, it.tag);
        if (force_tag != "") it.tag = force_tag;
        it.exp_x = fr;
        q.push_back(it);
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_item_t it;
            it = q.pop_front();
            total++;
            if (result !== it.exp_res || carry_out !== it.exp_c) begin
                fails++;
                $display("FAIL %s kind=%0d reg=%0b imm=%0d ramt=%0d src=%h cin=%0b: got %h/%0b expected %h/%0b",
                         it.tag, shift_kind, amt_from_reg, imm_amt, reg_amt, src_val, carry_in,
                         result, carry_out, it.exp_res, it.exp_c);
            end
            total++;
            if (extra_cycle !== it.exp_x) begin
                fails++;
                $display("FAIL R10 extra_cycle: got %0b expected %0b", extra_cycle, it.exp_x);
            end
        end
    end

    initial begin
        repeat (3000000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7F3C_A5E2;
        pats[2] = 32'hC0FF_EE11;
        pats[3] = 32'h0000_0000;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // state with idle inputs after reset (R4/R5 pass-through of zero)
        apply(2'd0, 1'b0, 5'd0, 8'd0, 32'h0, 1'b0, "R5");
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                for (int a = 0; a < 256; a++) begin
                    apply(2'(k), 1'b1, 5'h13, 8'(a), pats[p], 1'((a + p) % 2), "");
                end
                for (int a = 0; a < 32; a++) begin
                    apply(2'(k), 1'b0, 5'(a), 8'hA5, pats[p], 1'((a + k) % 2), "");
                end
            end
        end
        // R11: unselected amount field varies with no effect
        for (int j = 0; j < 6; j++) begin
            apply(2'd1, 1'b0, 5'd4, 8'(j * 51), 32'hDEAD_BEEF, 1'b1, "R11");
            apply(2'd3, 1'b1, 5'(j * 5), 8'd7, 32'h1234_5678, 1'b0, "R11");
        end
        @(posedge clk);
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule